// File: doc/BRIEF.md
# Lock-step SIMD Processing Grid with Torus Neighbour Links

This block is a rectangular grid of small integer processing elements. Each clock a controller may present one 96-bit instruction bundle, and every element executes it in the same cycle. Only the low 32-bit integer slot is decoded. The two upper slots are carried on the bus but have no effect.

Each element holds sixteen 32-bit registers, a zero flag, a status flag and an enable bit. Per-element predication uses a small stack of saved enable bits. A push narrows the enabled set to the elements whose last subtract or compare gave zero. A pop restores the saved enable bit. A transfer instruction moves one register from every element to its neighbour in a named direction, and the edges wrap, so the grid is a 2D torus. The transfer has no router, no queue and no arbitration. The status flags of all elements are OR-reduced into one line for the controller. A read port exposes one chosen register of every element at once.

A typical use is a reduction. Each element loads its value and runs (columns-1) rounds of east transfer plus add. It then copies the row sum and runs (rows-1) rounds of north transfer plus add. After that, every element holds the grand total.

Top module: `simd_torus_array`

## Requirements
- R1: After reset, every register of every element reads 0, all elements are enabled, and the OR-flag and the stack error line are 0.
- R2: Only bundle bits [31:0] are decoded, as op[31:26], rd[25:22], ra[21:18], rb[17:14], dir[13:12] and imm[11:0]. Bits [95:32], opcode 0 (no-op), opcodes above 11, and cycles with the bundle valid input low change no state.
- R3: For enabled elements, op 1 writes rd=ra+rb, op 2 writes rd=ra-rb, op 3 writes rd=ra+sext(imm), op 4 writes rd=sext(imm) and op 5 writes rd=ra, all modulo 2^32. Op 2 also sets the zero flag to (ra==rb), and op 6 sets the zero flag to (ra==rb) without writing any register.
- R4: Op 7 makes every element send register ra in direction dir (0 north = y+1, 1 east = x+1, 2 south, 3 west). Every enabled element writes the value it receives into rd. Coordinates wrap modulo the grid size.
- R5: Op 10 writes rd with an identity value chosen by imm[2:0]: 0 gives columns, 1 rows, 2 total elements, 3 x, 4 y, 5 ID = y*columns+x, and 6 or 7 give 0. Element (0,0) is the southwest corner.
- R6: Op 8, executed by all elements, saves the enable bit and then sets enable = enable AND zero flag. Op 9 restores the most recently saved bit, so the matching pop re-enables every element.
- R7: A disabled element commits no register write and no zero-flag or status-flag update. It still drives its outgoing transfer link.
- R8: A push on a full stack or a pop on an empty stack sets a sticky error line and leaves the enable bit unchanged. Only reset clears the error line.
- R9: Op 11 sets an element's status flag to (ra != 0). The OR-flag output is the OR of all status flags.
- R10: The reduction sequence leaves the grand total of all inputs in every element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bundle_valid_i | input | 1 | Bundle present this cycle |
| bundle_i | input | 96 | Instruction bundle, integer slot in [31:0] |
| rd_sel_i | input | 4 | Register index for the read port |
| rd_data_o | output | COLS*ROWS*DW | Selected register of each element, element ID k at [k*DW +: DW] |
| en_o | output | COLS*ROWS | Enable bit per element, bit k = element ID k |
| flag_any_o | output | 1 | OR of all element status flags |
| mask_err_o | output | 1 | OR of sticky stack over/underflow errors |

## Verification
The bench builds a 3-column, 2-row grid. Because the grid is not square, a swap of x and y, or of the column and row counts, shows up in the identity values, in the transfer sources and in the reduction total of 21. A wrap error in a single direction also shows up. The stack depth is set to 3, which keeps the overflow case to a few pushes and makes it cheap to reach. The overflow test pushes onto a full stack while some zero flags are clear, so any change to the enable bits would be visible. Masked transfers show that a disabled element still feeds its enabled neighbour.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int BUNDLE_W = 96;
  localparam int SLOT_W   = 32;
  localparam int REG_AW   = 4;
  localparam int NREG     = 1 << REG_AW;
  localparam int IMM_W    = 12;

  typedef enum logic [5:0] {
    OP_NOP    = 6'd0,
    OP_ADD    = 6'd1,
    OP_SUB    = 6'd2,
    OP_ADDI   = 6'd3,
    OP_MOVI   = 6'd4,
    OP_MOV    = 6'd5,
    OP_CMP    = 6'd6,
    OP_XFER   = 6'd7,
    OP_PUSHEQ = 6'd8,
    OP_POP    = 6'd9,
    OP_IDR    = 6'd10,
    OP_SETF   = 6'd11
  } op_e;

  typedef enum logic [1:0] {
    DIR_N = 2'd0,
    DIR_E = 2'd1,
    DIR_S = 2'd2,
    DIR_W = 2'd3
  } dir_e;

  typedef struct packed {
    logic [5:0]        op;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] ra;
    logic [REG_AW-1:0] rb;
    logic [1:0]        dir;
    logic [IMM_W-1:0]  imm;
  } islot_t;
endpackage

// File: rtl/simd_mask_stack.sv
module simd_mask_stack #(
  parameter int DEPTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic pop_i,
  input  logic cond_i,
  output logic en_o,
  output logic err_o
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] stk_q;
  logic [PW-1:0]    ptr_q;
  logic             en_q, err_q;
  logic [IW-1:0]    wr_idx, rd_idx;
  logic [PW-1:0]    ptr_dec;
  logic             full, empty;

  assign full    = (ptr_q == PW'(DEPTH));
  assign empty   = (ptr_q == '0);
  assign ptr_dec = ptr_q - 1'b1;
  assign wr_idx  = IW'(ptr_q);
  assign rd_idx  = IW'(ptr_dec);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stk_q <= '0;
      ptr_q <= '0;
      en_q  <= 1'b1;
      err_q <= 1'b0;
    end else if (push_i) begin
      if (full) err_q <= 1'b1;
      else begin
        stk_q[wr_idx] <= en_q;
        ptr_q         <= ptr_q + 1'b1;
        en_q          <= en_q & cond_i;
      end
    end else if (pop_i) begin
      if (empty) err_q <= 1'b1;
      else begin
        ptr_q <= ptr_dec;
        en_q  <= stk_q[rd_idx];
      end
    end
  end

  assign en_o  = en_q;
  assign err_o = err_q;
endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int DW     = 32,
  parameter int COLS   = 2,
  parameter int ROWS   = 2,
  parameter int X      = 0,
  parameter int Y      = 0,
  parameter int MDEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  islot_t            ins_i,
  input  logic [DW-1:0]     link_in_i,
  output logic [DW-1:0]     link_o,
  input  logic [REG_AW-1:0] rd_sel_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              en_o,
  output logic              flag_o,
  output logic              err_o
);
  localparam int ID  = Y * COLS + X;
  localparam int NPE = COLS * ROWS;

  logic [DW-1:0] regs_q [NREG];
  logic          zf_q, flag_q;
  logic [DW-1:0] op_a, op_b, imm_x, diff, ident, wval;
  logic          wr, zf_set, zf_val, flag_set, flag_val, commit, en;

  assign op_a  = regs_q[ins_i.ra];
  assign op_b  = regs_q[ins_i.rb];
  assign imm_x = {{(DW-IMM_W){ins_i.imm[IMM_W-1]}}, ins_i.imm};
  assign diff  = op_a - op_b;

  always_comb begin
    case (ins_i.imm[2:0])
      3'd0:    ident = DW'(COLS);
      3'd1:    ident = DW'(ROWS);
      3'd2:    ident = DW'(NPE);
      3'd3:    ident = DW'(X);
      3'd4:    ident = DW'(Y);
      3'd5:    ident = DW'(ID);
      default: ident = '0;
    endcase
  end

  always_comb begin
    wr       = 1'b0;
    wval     = '0;
    zf_set   = 1'b0;
    zf_val   = 1'b0;
    flag_set = 1'b0;
    flag_val = 1'b0;
    case (ins_i.op)
      OP_ADD:  begin wr = 1'b1; wval = op_a + op_b; end
      OP_SUB:  begin wr = 1'b1; wval = diff; zf_set = 1'b1; zf_val = (diff == '0); end
      OP_ADDI: begin wr = 1'b1; wval = op_a + imm_x; end
      OP_MOVI: begin wr = 1'b1; wval = imm_x; end
      OP_MOV:  begin wr = 1'b1; wval = op_a; end
      OP_CMP:  begin zf_set = 1'b1; zf_val = (op_a == op_b); end
      OP_XFER: begin wr = 1'b1; wval = link_in_i; end
      OP_IDR:  begin wr = 1'b1; wval = ident; end
      OP_SETF: begin flag_set = 1'b1; flag_val = (op_a != '0); end
      default: ;
    endcase
  end

  assign commit = valid_i && en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (commit && wr) begin
      regs_q[ins_i.rd] <= wval;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zf_q   <= 1'b0;
      flag_q <= 1'b0;
    end else if (commit) begin
      if (zf_set)   zf_q   <= zf_val;
      if (flag_set) flag_q <= flag_val;
    end
  end

  simd_mask_stack #(.DEPTH(MDEPTH)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (valid_i && (ins_i.op == OP_PUSHEQ)),
    .pop_i  (valid_i && (ins_i.op == OP_POP)),
    .cond_i (zf_q),
    .en_o   (en),
    .err_o  (err_o)
  );

  // link stays driven even when masked off
  assign link_o    = op_a;
  assign rd_data_o = regs_q[rd_sel_i];
  assign en_o      = en;
  assign flag_o    = flag_q;
endmodule

// File: rtl/simd_torus_array.sv
module simd_torus_array
  import simd_pkg::*;
#(
  parameter int COLS   = 2,
  parameter int ROWS   = 2,
  parameter int DW     = 32,
  parameter int MDEPTH = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bundle_valid_i,
  input  logic [BUNDLE_W-1:0]      bundle_i,
  input  logic [REG_AW-1:0]        rd_sel_i,
  output logic [COLS*ROWS*DW-1:0]  rd_data_o,
  output logic [COLS*ROWS-1:0]     en_o,
  output logic                     flag_any_o,
  output logic                     mask_err_o
);
  localparam int NPE = COLS * ROWS;

  islot_t        ins;
  logic [DW-1:0] link_w [NPE];
  logic [NPE-1:0] flag_w, err_w;

  assign ins = islot_t'(bundle_i[SLOT_W-1:0]);

  for (genvar gy = 0; gy < ROWS; gy++) begin : g_row
    for (genvar gx = 0; gx < COLS; gx++) begin : g_col
      localparam int P     = gy * COLS + gx;
      localparam int SRC_N = ((gy + ROWS - 1) % ROWS) * COLS + gx;
      localparam int SRC_E = gy * COLS + (gx + COLS - 1) % COLS;
      localparam int SRC_S = ((gy + 1) % ROWS) * COLS + gx;
      localparam int SRC_W = gy * COLS + (gx + 1) % COLS;

      logic [DW-1:0] rx;
      always_comb begin
        case (ins.dir)
          DIR_N:   rx = link_w[SRC_N];
          DIR_E:   rx = link_w[SRC_E];
          DIR_S:   rx = link_w[SRC_S];
          default: rx = link_w[SRC_W];
        endcase
      end

      simd_pe #(
        .DW(DW), .COLS(COLS), .ROWS(ROWS), .X(gx), .Y(gy), .MDEPTH(MDEPTH)
      ) u_pe (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .valid_i   (bundle_valid_i),
        .ins_i     (ins),
        .link_in_i (rx),
        .link_o    (link_w[P]),
        .rd_sel_i  (rd_sel_i),
        .rd_data_o (rd_data_o[P*DW +: DW]),
        .en_o      (en_o[P]),
        .flag_o    (flag_w[P]),
        .err_o     (err_w[P])
      );
    end
  end

  assign flag_any_o = |flag_w;
  assign mask_err_o = |err_w;
endmodule

// File: rtl/simd_torus_checker.sv
module simd_torus_checker
  import simd_pkg::*;
#(
  parameter int NPE = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           bundle_valid_i,
  input logic [5:0]     op_i,
  input logic [NPE-1:0] en_i,
  input logic           flag_i,
  input logic           err_i
);
  logic is_mask_op;
  assign is_mask_op = (op_i == OP_PUSHEQ) || (op_i == OP_POP);

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bundle_valid_i |=> ($stable(en_i) && $stable(flag_i) && $stable(err_i)));

  p_push_narrows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bundle_valid_i && op_i == OP_PUSHEQ) |=> ((en_i & ~$past(en_i)) == '0));

  p_en_mask_ops_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bundle_valid_i && !is_mask_op) |=> $stable(en_i));

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_i);

  p_err_mask_ops_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bundle_valid_i && !is_mask_op) |=> $stable(err_i));

  p_flag_setf_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bundle_valid_i && op_i != OP_SETF) |=> $stable(flag_i));
endmodule

bind simd_torus_array simd_torus_checker #(.NPE(COLS*ROWS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .bundle_valid_i (bundle_valid_i),
  .op_i           (bundle_i[31:26]),
  .en_i           (en_o),
  .flag_i         (flag_any_o),
  .err_i          (mask_err_o)
);

// File: tb/tb_simd_torus_array.sv
module tb_simd_torus_array;
  localparam int CLK_P  = 10;
  localparam int COLS   = 3;
  localparam int ROWS   = 2;
  localparam int MDEPTH = 3;
  localparam int NPE    = COLS * ROWS;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid = 1'b0;
  logic [95:0]       bundle = '0;
  logic [3:0]        rd_sel = '0;
  logic [NPE*32-1:0] rd_data;
  logic [NPE-1:0]    en;
  logic              flag_any, merr;

  simd_torus_array #(.COLS(COLS), .ROWS(ROWS), .DW(32), .MDEPTH(MDEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bundle_valid_i(valid), .bundle_i(bundle),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .en_o(en),
    .flag_any_o(flag_any), .mask_err_o(merr)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;

  logic [31:0] mreg [NPE][16];
  logic        men  [NPE];
  logic        mzf  [NPE];
  logic        mflg [NPE];
  logic        merr_q [NPE];
  logic        mstk [NPE][MDEPTH];
  int          mptr [NPE];

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    report();
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [95:0] mk(int op, int rd, int ra, int rb, int dir, int imm);
    logic [31:0] s;
    s = {6'(op), 4'(rd), 4'(ra), 4'(rb), 2'(dir), 12'(imm)};
    return {32'hC0DE_F00D, 32'h1234_ABCD, s};
  endfunction

  function automatic int src_of(int p, int dir);
    int x = p % COLS, y = p / COLS;
    case (dir)
      0: return ((y + ROWS - 1) % ROWS) * COLS + x;
      1: return y * COLS + (x + COLS - 1) % COLS;
      2: return ((y + 1) % ROWS) * COLS + x;
      default: return y * COLS + (x + 1) % COLS;
    endcase
  endfunction

  task automatic model_reset();
    for (int p = 0; p < NPE; p++) begin
      for (int r = 0; r < 16; r++) mreg[p][r] = '0;
      men[p] = 1'b1; mzf[p] = 1'b0; mflg[p] = 1'b0; merr_q[p] = 1'b0; mptr[p] = 0;
      for (int d = 0; d < MDEPTH; d++) mstk[p][d] = 1'b0;
    end
  endtask

  task automatic model_step(logic [95:0] b);
    int op = int'(b[31:26]);
    int rd = int'(b[25:22]), ra = int'(b[21:18]), rb = int'(b[17:14]);
    int dir = int'(b[13:12]);
    logic [31:0] ix = {{20{b[11]}}, b[11:0]};
    logic [31:0] snd [NPE];
    for (int p = 0; p < NPE; p++) snd[p] = mreg[p][ra];
    for (int p = 0; p < NPE; p++) begin
      logic [31:0] a = mreg[p][ra], bb = mreg[p][rb], idv;
      case (int'(b[2:0]))
        0: idv = COLS; 1: idv = ROWS; 2: idv = NPE;
        3: idv = p % COLS; 4: idv = p / COLS; 5: idv = p;
        default: idv = 0;
      endcase
      if (op == 8) begin
        if (mptr[p] == MDEPTH) merr_q[p] = 1'b1;
        else begin mstk[p][mptr[p]] = men[p]; mptr[p]++; men[p] = men[p] & mzf[p]; end
      end else if (op == 9) begin
        if (mptr[p] == 0) merr_q[p] = 1'b1;
        else begin mptr[p]--; men[p] = mstk[p][mptr[p]]; end
      end else if (men[p]) begin
        case (op)
          1: mreg[p][rd] = a + bb;
          2: begin mreg[p][rd] = a - bb; mzf[p] = (a == bb); end
          3: mreg[p][rd] = a + ix;
          4: mreg[p][rd] = ix;
          5: mreg[p][rd] = a;
          6: mzf[p] = (a == bb);
          7: mreg[p][rd] = snd[src_of(p, dir)];
          10: mreg[p][rd] = idv;
          11: mflg[p] = (a != 0);
          default: ;
        endcase
      end
    end
  endtask

  task automatic check_all(string tag);
    logic [NPE-1:0] e;
    logic f, er;
    f = 1'b0; er = 1'b0;
    for (int p = 0; p < NPE; p++) begin
      e[p] = men[p]; f |= mflg[p]; er |= merr_q[p];
    end
    chk({tag, " en"}, 32'(en), 32'(e));
    chk({tag, " flag"}, 32'(flag_any), 32'(f));
    chk({tag, " err"}, 32'(merr), 32'(er));
    for (int r = 0; r < 16; r++) begin
      rd_sel = 4'(r);
      #1;
      for (int p = 0; p < NPE; p++) chk({tag, " reg"}, rd_data[p*32 +: 32], mreg[p][r]);
    end
  endtask

  task automatic issue(logic [95:0] b, string tag);
    @(negedge clk);
    bundle = b; valid = 1'b1;
    @(posedge clk);
    #1;
    valid = 1'b0;
    model_step(b);
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; valid = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    model_reset();
    do_reset();
    #1 check_all("R1 reset");

    // identity registers r1..r6
    for (int k = 0; k < 6; k++) issue(mk(10, k + 1, 0, 0, 0, k), "R5 ident");
    issue(mk(10, 7, 0, 0, 0, 7), "R5 ident-undef");

    // unused slots, no-op, undefined opcode, idle
    issue(mk(0, 1, 2, 3, 1, 12'hFFF), "R2 nop");
    issue(mk(63, 1, 2, 3, 1, 5), "R2 undef-op");
    @(negedge clk); bundle = mk(4, 1, 0, 0, 0, 77); valid = 1'b0;
    @(posedge clk); #1; check_all("R2 valid-low");

    // arithmetic
    issue(mk(4, 7, 0, 0, 0, -5), "R3 movi");
    issue(mk(3, 8, 7, 0, 0, 2047), "R3 addi");
    issue(mk(1, 9, 7, 6, 0, 0), "R3 add");
    issue(mk(2, 10, 1, 6, 0, 0), "R3 sub");
    issue(mk(5, 11, 10, 0, 0, 0), "R3 mov");
    issue(mk(3, 11, 11, 0, 0, -2048), "R3 addi-neg");

    // torus transfers, all four directions
    for (int d = 0; d < 4; d++) issue(mk(7, 12 + d, 6, 0, d, 0), "R4 xfer");

    // reduction, inputs id+1
    issue(mk(3, 1, 6, 0, 0, 1), "R10 load");
    issue(mk(5, 2, 1, 0, 0, 0), "R10 copy");
    for (int i = 0; i < COLS - 1; i++) begin
      issue(mk(7, 1, 1, 0, 1, 0), "R10 east");
      issue(mk(1, 2, 2, 1, 0, 0), "R10 add");
    end
    issue(mk(5, 1, 2, 0, 0, 0), "R10 rowcopy");
    for (int i = 0; i < ROWS - 1; i++) begin
      issue(mk(7, 1, 1, 0, 0, 0), "R10 north");
      issue(mk(1, 2, 2, 1, 0, 0), "R10 add");
    end
    rd_sel = 4'd2; #1;
    for (int p = 0; p < NPE; p++) chk("R10 total", rd_data[p*32 +: 32], 32'd21);

    // masking: only element 0 has id == 0
    issue(mk(4, 0, 0, 0, 0, 0), "R3 clear r0");
    issue(mk(6, 0, 6, 0, 0, 0), "R3 cmp");
    issue(mk(8, 0, 0, 0, 0, 0), "R6 push");
    chk("R6 single-enabled", 32'(en), 32'(6'b000001));
    issue(mk(4, 4, 0, 0, 0, 99), "R7 masked-write");
    issue(mk(7, 5, 6, 0, 1, 0), "R7 masked-xfer");
    issue(mk(11, 0, 4, 0, 0, 0), "R7 masked-setf");
    issue(mk(2, 3, 6, 0, 0, 0), "R7 masked-zf");
    issue(mk(6, 0, 4, 4, 0, 0), "R6 cmp-nested");
    issue(mk(8, 0, 0, 0, 0, 0), "R6 push-nested");
    issue(mk(9, 0, 0, 0, 0, 0), "R6 pop");
    issue(mk(9, 0, 0, 0, 0, 0), "R6 pop-all");
    chk("R6 all-enabled", 32'(en), 32'(6'b111111));

    // status OR
    issue(mk(11, 0, 0, 0, 0, 0), "R9 setf-zero");
    issue(mk(11, 0, 6, 0, 0, 0), "R9 setf-some");
    issue(mk(11, 0, 0, 0, 0, 0), "R9 setf-clear");

    // stack overflow with some zero flags clear
    issue(mk(6, 0, 0, 0, 0, 0), "R8 cmp-all");
    for (int i = 0; i < MDEPTH; i++) issue(mk(8, 0, 0, 0, 0, 0), "R8 fill");
    issue(mk(6, 0, 6, 0, 0, 0), "R8 cmp-one");
    issue(mk(8, 0, 0, 0, 0, 0), "R8 overflow");
    chk("R8 overflow-en", 32'(en), 32'(6'b111111));
    issue(mk(1, 3, 3, 3, 0, 0), "R8 sticky");
    for (int i = 0; i < MDEPTH; i++) issue(mk(9, 0, 0, 0, 0, 0), "R8 drain");

    // underflow after fresh reset
    do_reset();
    #1 check_all("R1 re-reset");
    issue(mk(9, 0, 0, 0, 0, 0), "R8 underflow");
    chk("R8 underflow-err", 32'(merr), 32'd1);

    report();
  end
endmodule